// File: doc/BRIEF.md
# Section Trace Byte Monitor

The block watches the section trace overhead byte. That byte arrives once per frame and is presented on a byte input with a valid strobe. A 3-bit mode input selects one of six ways of handling it.

The first group of modes captures the trace message into a 16-entry store and flags any byte that differs from what the same message position held on the previous pass. This is done either free-running or aligned to a SONET-style or SDH-style message start. A second group compares the aligned incoming message against 16 expected bytes that software writes in. A persistence mode accepts a new single-byte value only after it has arrived in a programmable number of consecutive frames.

A mismatch state output reports a difference. A sticky change flag records every transition of that state, or every accepted value in persistence mode. An interrupt output is that flag gated by a mask bit. A small write port loads the expected bytes, the persistence threshold and the mask, and clears the change flag. A read port gives access to the captured store.

Top module: `trace_mon`

## Requirements
- R1: After reset, mism, delta and irq are 0 and every captured entry reads 0.
- R2: In mode 000 each valid byte is compared with the captured entry at the current position and then written there. The position advances circularly through entries 0 to 15. A differing byte sets mism in the cycle after it is presented.
- R3: In every compare mode (000, 001, 010, 100, 101), mism returns to 0 after 16 consecutive compared bytes with no difference. A difference restarts that run.
- R4: In mode 001 a byte equal to 0x0A is compared and stored at the current position, and the next byte goes to entry 0. Other bytes advance the position circularly.
- R5: In mode 010 a byte with bit 7 set is compared and stored at entry 0, and the following bytes go to entries 1, 2 and onward.
- R6: Modes 100 and 101 use the alignment of 001 and 010 respectively. They compare each byte with the expected entry written at write address 0..15 instead of the captured entry, and they still store the received byte in the captured store.
- R7: In mode 011 the threshold is write address 16, bits [3:0], with 0 acting as 1. A byte that differs from entry 0 is written into entry 0, and sets delta, on the threshold-th consecutive arrival of that same byte. Any other byte in between restarts the run. mism is held at 0 in this mode.
- R8: delta is set in the cycle after any change of mism in a compare mode. irq equals delta while the mask (write address 17, bit 0) is 1, and is 0 while the mask is 0.
- R9: A write to address 18 with bit 0 set clears delta in the next cycle. When a set event falls in the same cycle, delta stays 1. Without either, delta holds its value.
- R10: In modes 110 and 111, mism, delta and irq are 0 from the cycle after the mode is applied, and valid bytes leave the captured store unchanged.
- R11: A change of the mode input resets the message position, the clean run and the persistence run to zero. A valid byte presented in the cycle the mode changes is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Monitoring mode select |
| byte_valid | input | 1 | Trace byte strobe, one per frame |
| byte_in | input | 8 | Received trace byte |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | 0..15 expected bytes, 16 threshold, 17 mask, 18 change-flag clear |
| wr_data | input | 8 | Register write data |
| cap_rd_addr | input | 4 | Captured store read index |
| cap_rd_data | output | 8 | Captured store entry at cap_rd_addr |
| mism | output | 1 | Mismatch state |
| delta | output | 1 | Sticky change flag |
| irq | output | 1 | Masked interrupt |

## Verification
The two events that can meet in one cycle are a set of the change flag and a write-one-to-clear of it. The bench provokes this by presenting the sixteenth clean byte, which drops the mismatch state, in the same cycle as the clear write. It judges the result by seeing delta still 1 the cycle after. A lone clear that follows must then bring delta to 0.

// File: rtl/trace_mon.sv
module trace_mon #(
  parameter int MSG_LEN = 16,
  parameter int W = 8,
  parameter int THR_W = 4,
  parameter logic [W-1:0] SONET_MARK = 8'h0A
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 mode,
  input  logic                       byte_valid,
  input  logic [W-1:0]               byte_in,
  input  logic                       wr_en,
  input  logic [$clog2(MSG_LEN+3)-1:0] wr_addr,
  input  logic [W-1:0]               wr_data,
  input  logic [$clog2(MSG_LEN)-1:0] cap_rd_addr,
  output logic [W-1:0]               cap_rd_data,
  output logic                       mism,
  output logic                       delta,
  output logic                       irq
);
  localparam int PW = $clog2(MSG_LEN);
  localparam int AW = $clog2(MSG_LEN + 3);
  localparam int CW = $clog2(MSG_LEN + 1);
  localparam logic [AW-1:0] A_THR  = AW'(MSG_LEN);
  localparam logic [AW-1:0] A_MASK = AW'(MSG_LEN + 1);
  localparam logic [AW-1:0] A_CLR  = AW'(MSG_LEN + 2);
  localparam logic [2:0] M_SONET = 3'b001, M_SDH = 3'b010, M_PERS = 3'b011,
                         M_XSONET = 3'b100, M_XSDH = 3'b101;

  logic [W-1:0]     cap [MSG_LEN];
  logic [W-1:0]     exp_mem [MSG_LEN];
  logic [2:0]       mode_q;
  logic [PW-1:0]    ptr;
  logic [CW-1:0]    clean;
  logic [THR_W-1:0] thr, pcnt;
  logic [W-1:0]     cand;
  logic             mask_q, mism_q, delta_q;

  wire mode_chg = mode != mode_q;
  wire undef    = mode[2:1] == 2'b11;
  wire pers     = mode == M_PERS;
  wire sdh      = (mode == M_SDH) || (mode == M_XSDH);
  wire sonet    = (mode == M_SONET) || (mode == M_XSONET);
  wire vs_exp   = (mode == M_XSONET) || (mode == M_XSDH);
  wire take     = byte_valid && !mode_chg && !undef;
  wire cmp_take = take && !pers;

  wire [PW-1:0] pos    = (sdh && byte_in[W-1]) ? '0 : ptr;
  wire          at_end = pos == PW'(MSG_LEN - 1);
  wire [PW-1:0] ptr_nx = ((sonet && byte_in == SONET_MARK) || at_end) ? '0 : pos + 1'b1;
  wire [W-1:0]  ref_b  = vs_exp ? exp_mem[pos] : cap[pos];
  wire          diff   = byte_in != ref_b;
  wire          last_clean = clean == CW'(MSG_LEN - 1);

  logic mism_nx;
  always_comb begin
    mism_nx = mism_q;
    if (undef || pers) mism_nx = 1'b0;
    else if (cmp_take) mism_nx = diff ? 1'b1 : (last_clean ? 1'b0 : mism_q);
  end

  wire             run     = (pcnt != '0) && (byte_in == cand);
  wire [THR_W:0]   run_len = run ? {1'b0, pcnt} + 1'b1 : (THR_W+1)'(1);
  wire [THR_W:0]   thr_eff = (thr == '0) ? (THR_W+1)'(1) : {1'b0, thr};
  wire             fresh   = take && pers && (byte_in != cap[0]);
  wire             accept  = fresh && (run_len >= thr_eff);

  wire set_ev = (!undef && !pers && (mism_nx != mism_q)) || accept;
  wire clr_ev = wr_en && (wr_addr == A_CLR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ptr    <= '0;
      clean  <= '0;
      pcnt   <= '0;
      cand   <= '0;
      thr    <= '0;
      mask_q <= 1'b0;
      mism_q <= 1'b0;
      delta_q <= 1'b0;
      for (int i = 0; i < MSG_LEN; i++) begin
        cap[i]     <= '0;
        exp_mem[i] <= '0;
      end
    end else begin
      mode_q <= mode;
      mism_q <= mism_nx;

      if (undef)       delta_q <= 1'b0;
      else if (set_ev) delta_q <= 1'b1;
      else if (clr_ev) delta_q <= 1'b0;

      if (wr_en && wr_addr < A_THR) exp_mem[wr_addr[PW-1:0]] <= wr_data;
      if (wr_en && wr_addr == A_THR)  thr    <= wr_data[THR_W-1:0];
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[0];

      if (mode_chg) begin
        ptr   <= '0;
        clean <= '0;
        pcnt  <= '0;
      end else begin
        if (cmp_take) begin
          cap[pos] <= byte_in;
          ptr      <= ptr_nx;
          if (diff || last_clean) clean <= '0;
          else                    clean <= clean + 1'b1;
        end
        if (take && pers) begin
          if (!fresh) pcnt <= '0;
          else if (accept) begin
            cap[0] <= byte_in;
            pcnt   <= '0;
          end else begin
            cand <= byte_in;
            pcnt <= run_len[THR_W-1:0];
          end
        end
      end
    end
  end

  assign cap_rd_data = cap[cap_rd_addr];
  assign mism  = mism_q;
  assign delta = delta_q;
  assign irq   = delta_q & mask_q;
endmodule

// File: rtl/trace_mon_chk.sv
module trace_mon_chk #(
  parameter int MSG_LEN = 16,
  parameter int W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [2:0]                   mode,
  input logic                         wr_en,
  input logic [$clog2(MSG_LEN+3)-1:0] wr_addr,
  input logic [W-1:0]                 wr_data,
  input logic                         mism,
  input logic                         delta,
  input logic                         irq
);
  localparam int AW = $clog2(MSG_LEN + 3);
  wire clr = wr_en && (wr_addr == AW'(MSG_LEN + 2)) && wr_data[0];

  p_delta_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != 3'b011 && $past(mode[2:1]) != 2'b11 && mism != $past(mism)) |-> delta);

  p_irq_needs_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> delta);

  p_delta_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(delta) && !$past(clr) && $past(mode[2:1]) != 2'b11) |-> delta);

  p_idle_undef_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode[2:1] == 2'b11) |-> (!mism && !delta && !irq));

  p_pers_no_mism_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode) == 3'b011 |-> !mism);
endmodule

bind trace_mon trace_mon_chk #(.MSG_LEN(MSG_LEN), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mism(mism), .delta(delta), .irq(irq));

// File: tb/trace_mon_tb.sv
module trace_mon_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 3'b000;
  logic byte_valid = 0, wr_en = 0;
  logic [7:0] byte_in = 0, wr_data = 0, cap_rd_data;
  logic [4:0] wr_addr = 0;
  logic [3:0] cap_rd_addr = 0;
  logic mism, delta, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trace_mon u_dut (.clk(clk), .rst_n(rst_n), .mode(mode), .byte_valid(byte_valid),
    .byte_in(byte_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_rd_addr(cap_rd_addr), .cap_rd_data(cap_rd_data),
    .mism(mism), .delta(delta), .irq(irq));

  function automatic logic [7:0] pv(int i); return 8'(i * 7 + 3); endfunction
  function automatic logic [7:0] sv(int i); return (i == 15) ? 8'h0A : 8'(8'h30 + i); endfunction
  function automatic logic [7:0] dv(int i); return (i == 0) ? 8'hC1 : 8'(8'h40 + i); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    byte_valid = 1; byte_in = b;
    @(negedge clk);
    byte_valid = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic setmode(logic [2:0] m);
    mode = m;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic capchk(string req, int i, logic [7:0] exp);
    cap_rd_addr = 4'(i);
    #0.5;
    chk(req, cap_rd_data, exp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mism", mism, 0); chk("R1 delta", delta, 0); chk("R1 irq", irq, 0);
    for (int i = 0; i < 16; i++) capchk("R1 cap", i, 0);

    // R2 free-running capture and compare
    send(pv(0));
    chk("R2 mism set", mism, 1); chk("R8 delta set", delta, 1);
    for (int i = 1; i < 16; i++) send(pv(i));
    for (int i = 0; i < 15; i++) send(pv(i));
    chk("R3 still set after 15 clean", mism, 1);
    send(pv(15));
    chk("R3 cleared after 16 clean", mism, 0);
    for (int i = 0; i < 16; i++) capchk("R2 cap", i, pv(i));

    // R8 mask, R9 clear and collision
    chk("R8 irq masked", irq, 0);
    wr(5'd17, 8'h01);
    chk("R8 irq unmasked", irq, 1);
    wr(5'd18, 8'h01);
    chk("R9 clear", delta, 0); chk("R8 irq after clear", irq, 0);
    send(pv(0) ^ 8'h01);
    chk("R2 mism on diff", mism, 1); chk("R8 delta again", delta, 1);
    wr(5'd18, 8'h01);
    for (int i = 1; i < 16; i++) send(pv(i));
    chk("R9 delta holds", delta, 0); chk("R3 mism pending", mism, 1);
    byte_valid = 1; byte_in = pv(0) ^ 8'h01;
    wr_en = 1; wr_addr = 5'd18; wr_data = 8'h01;
    @(negedge clk);
    byte_valid = 0; wr_en = 0;
    chk("R3 cleared at collision", mism, 0);
    chk("R9 set wins over clear", delta, 1);
    wr(5'd18, 8'h01);
    chk("R9 lone clear", delta, 0);

    // R4 SONET alignment
    setmode(3'b001);
    send(8'h0A);
    for (int r = 0; r < 2; r++) for (int i = 0; i < 16; i++) send(sv(i));
    chk("R4 mism clean", mism, 0);
    for (int i = 0; i < 5; i++) send(8'(8'h21 + i));
    send(8'h0A);
    for (int i = 0; i < 16; i++) send(sv(i));
    chk("R4 mism after misalign", mism, 1);
    for (int i = 0; i < 16; i++) capchk("R4 realigned cap", i, sv(i));

    // R5 SDH alignment
    setmode(3'b010);
    send(8'h01); send(8'h02); send(8'h03);
    for (int r = 0; r < 3; r++) for (int i = 0; i < 16; i++) send(dv(i));
    for (int i = 0; i < 16; i++) capchk("R5 cap", i, dv(i));
    chk("R5 R3 mism clean", mism, 0);

    // R6 expected compare, SONET then SDH
    for (int i = 0; i < 16; i++) wr(5'(i), sv(i));
    setmode(3'b100);
    wr(5'd18, 8'h01);
    for (int r = 0; r < 2; r++) for (int i = 0; i < 16; i++) send(sv(i));
    chk("R6 no mism", mism, 0); chk("R6 no delta", delta, 0);
    for (int i = 0; i < 16; i++) capchk("R6 cap", i, sv(i));
    for (int i = 0; i < 8; i++) send(i == 7 ? sv(7) ^ 8'h10 : sv(i));
    chk("R6 mism", mism, 1);
    for (int i = 8; i < 16; i++) send(sv(i));
    for (int i = 0; i < 16; i++) send(sv(i));
    chk("R6 R3 recovered", mism, 0);
    for (int i = 0; i < 16; i++) wr(5'(i), dv(i));
    setmode(3'b101);
    for (int r = 0; r < 2; r++) for (int i = 0; i < 16; i++) send(dv(i));
    chk("R6 sdh clean", mism, 0);
    for (int i = 0; i < 4; i++) send(i == 3 ? 8'h7E : dv(i));
    chk("R6 sdh mism", mism, 1);

    // R7 persistence, threshold sweep
    setmode(3'b011);
    chk("R7 mism held 0", mism, 0);
    for (int t = 1; t <= 5; t++) begin
      wr(5'd16, 8'(t));
      wr(5'd18, 8'h01);
      for (int k = 0; k < t - 1; k++) send(8'(8'h90 + t));
      capchk("R7 not yet", 0, (t == 1) ? 8'hC1 : 8'(8'h90 + t - 1));
      chk("R7 no delta yet", delta, 0);
      send(8'(8'h90 + t));
      capchk("R7 accepted", 0, 8'(8'h90 + t));
      chk("R7 delta on accept", delta, 1);
    end
    wr(5'd16, 8'h03);
    send(8'h66); send(8'h66); send(8'h77); send(8'h66); send(8'h66);
    capchk("R7 run restart", 0, 8'h95);
    send(8'h66);
    capchk("R7 accept after restart", 0, 8'h66);
    chk("R7 mism", mism, 0);

    // R10 undefined mode, R11 drop on mode change
    mode = 3'b110; byte_valid = 1; byte_in = 8'h11;
    @(negedge clk);
    byte_valid = 0;
    @(negedge clk);
    chk("R10 delta", delta, 0); chk("R10 irq", irq, 0); chk("R10 mism", mism, 0);
    send(8'h77); send(8'h78);
    capchk("R10 store unchanged", 0, 8'h66);
    capchk("R10 store unchanged", 1, dv(1));
    mode = 3'b000; byte_valid = 1; byte_in = 8'hEE;
    @(negedge clk);
    byte_valid = 0;
    @(negedge clk);
    capchk("R11 dropped byte", 0, 8'h66);
    send(8'h66);
    chk("R11 pointer reset", mism, 0);
    send(8'h55);
    capchk("R11 position 1", 1, 8'h55);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule